// File: doc/BRIEF.md
# Double-Buffered 8-bit Compare PWM

This block drives a single pulse-width-modulated pin. An 8-bit up-counter advances once per enable tick, so an external prescaler sets the PWM frequency, and it rolls from 255 back to 0 to form a period of 256 ticks. The pin is high while the count is at or above the active compare value and low below it. As a result a larger compare value gives a shorter high time: 0 keeps the pin high all the time, 128 gives half duty, and 255 gives one high tick in 256.

Software changes the duty by pulsing a write strobe with a new value. The value lands in a shadow register and takes effect only at the next counter wrap. Every period therefore runs with a single, whole compare value, and the pin never shows a runt pulse or a doubled edge when the duty changes.

Top module: `cmp_pwm`

## Requirements
- R1: A synchronous active-high reset clears the counter, the shadow value and the active compare value to 0, so the pin is high on the first cycle after reset and stays high until a nonzero duty has been written and loaded.
- R2: The counter changes only on a clock edge where the tick input is 1, and then it increments by one. With tick at 0 the counter, and therefore the pin, hold their values for any number of cycles.
- R3: The pin is 1 when the count is greater than or equal to the active compare value and 0 otherwise. With an active value of 192 the pin is 0 at count 191 and 1 at count 192.
- R4: Over one full period of 256 ticks that starts at count 0, the pin is high for exactly 256 minus V ticks, where V is the active value. Examples: V=0 gives 256, V=25 gives 231, V=128 gives 128, V=230 gives 26, V=255 gives 1.
- R5: A write strobe stores the duty input into the shadow register only. The active value, and with it the pin waveform, is unchanged for the rest of the current period.
- R6: On a tick edge where the count is 255, the count becomes 0 and the active value is loaded from the shadow register on the same edge.
- R7: When a write and a wrap occur on the same edge, the wrap loads the shadow value held before that edge. The newly written value goes into the shadow and takes effect at the following wrap.
- R8: When several writes occur within one period, the last one before the wrap is the value that gets loaded. Writes are accepted whether or not tick is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter enable / prescaler tick |
| wr_en | input | 1 | Write strobe for a new duty value |
| duty_in | input | 8 | Compare value to store into the shadow register |
| pwm_o | output | 1 | PWM output pin |

## Verification
The bench measures the high time over whole periods at the extremes of the range (0, 1, 255) and at several values in between. A design with an off-by-one comparison would report 255 or 257 there, and a design that inverted the encoding would report V instead of 256 minus V. It writes in the middle of a period and checks that the current period keeps its shape, which catches a missing shadow register. It also writes on the exact wrap edge and writes twice in one period, which exposes a load that takes the new value too early or keeps the first write. Long stretches without ticks show whether the counter runs away without its enable, and the bench probes the pin at the counts just below and at the compare value.

// File: rtl/cmp_pwm_pkg.sv
package cmp_pwm_pkg;

    // Default width of the period counter and the compare value.
    localparam int unsigned PWM_W = 8;

    // Per-cycle events produced by the counter stage.
    typedef struct packed {
        logic advance;   // counter moves on this edge
        logic wrap;      // counter moves from its top value to zero
    } cnt_evt_t;

    // Per-cycle request into the duty buffer stage.
    typedef struct packed {
        logic write;     // store new value into shadow
        logic load;      // copy shadow into active
    } duty_req_t;

    // Top value of a W-bit counter, as a W-bit pattern.
    function automatic logic [31:0] top_value(input int unsigned w);
        return (32'd1 << w) - 32'd1;
    endfunction

endpackage

// File: rtl/cmp_pwm_counter.sv
module cmp_pwm_counter
    import cmp_pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    output logic [W-1:0] count,
    output cnt_evt_t     evt
);
    localparam logic [W-1:0] TOP = W'(top_value(W));

    logic [W-1:0] count_q;

    always_comb begin
        evt.advance = tick;
        evt.wrap    = tick && (count_q == TOP);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (evt.advance) begin
            count_q <= count_q + W'(1);
        end
    end

    assign count = count_q;

    p_hold_no_tick_r2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count_q));

    p_step_on_tick_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> (count_q == W'($past(count_q) + W'(1))));

    p_wrap_to_zero_r6: assert property (@(posedge clk) disable iff (rst)
        evt.wrap |=> (count_q == '0));

endmodule

// File: rtl/cmp_pwm_duty_buf.sv
module cmp_pwm_duty_buf
    import cmp_pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  duty_req_t    req,
    input  logic [W-1:0] duty_in,
    output logic [W-1:0] active
);
    logic [W-1:0] shadow_q;
    logic [W-1:0] active_q;

    // Shadow register: last written value wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (req.write) begin
            shadow_q <= duty_in;
        end
    end

    // Active register: takes the shadow value held before this edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= '0;
        end else if (req.load) begin
            active_q <= shadow_q;
        end
    end

    assign active = active_q;

    p_active_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !req.load |=> $stable(active_q));

    p_load_old_shadow_r7: assert property (@(posedge clk) disable iff (rst)
        req.load |=> (active_q == $past(shadow_q)));

    p_shadow_capture_r8: assert property (@(posedge clk) disable iff (rst)
        req.write |=> (shadow_q == $past(duty_in)));

    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !req.write |=> $stable(shadow_q));

endmodule

// File: rtl/cmp_pwm_compare.sv
module cmp_pwm_compare #(
    parameter int unsigned W = cmp_pwm_pkg::PWM_W
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] active,
    output logic         level
);
    always_comb begin
        level = (count >= active);
    end
endmodule

// File: rtl/cmp_pwm.sv
module cmp_pwm
    import cmp_pwm_pkg::*;
#(
    parameter int unsigned W = PWM_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [W-1:0] duty_in,
    output logic         pwm_o
);
    logic [W-1:0] count;
    logic [W-1:0] active;
    cnt_evt_t     evt;
    duty_req_t    req;

    cmp_pwm_counter #(.W(W)) u_counter (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .count (count),
        .evt   (evt)
    );

    always_comb begin
        req.write = wr_en;
        req.load  = evt.wrap;
    end

    cmp_pwm_duty_buf #(.W(W)) u_duty (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .duty_in (duty_in),
        .active  (active)
    );

    cmp_pwm_compare #(.W(W)) u_cmp (
        .count  (count),
        .active (active),
        .level  (pwm_o)
    );

    p_reset_high_r1: assert property (@(posedge clk)
        rst |=> pwm_o);

    p_zero_always_high_r4: assert property (@(posedge clk) disable iff (rst)
        (active == '0) |-> pwm_o);

    p_low_at_count_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && (active != '0)) |-> !pwm_o);

    p_high_at_top_r3: assert property (@(posedge clk) disable iff (rst)
        (count == W'(top_value(W))) |-> pwm_o);

endmodule

// File: tb/cmp_pwm_tb.sv
module cmp_pwm_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] duty_in = 8'd0;
    logic       pwm_o;

    int errors = 0;
    int checks = 0;

    // Bench model of the requirements
    int m_cnt = 0;
    int m_shadow = 0;
    int m_active = 0;

    always #5 clk = ~clk;

    cmp_pwm u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .wr_en(wr_en), .duty_in(duty_in), .pwm_o(pwm_o)
    );

    typedef struct packed {
        logic [7:0] duty;
        logic [8:0] high;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{8'd0,   9'd256},
        '{8'd128, 9'd128},
        '{8'd255, 9'd1},
        '{8'd25,  9'd231},
        '{8'd230, 9'd26},
        '{8'd1,   9'd255},
        '{8'd64,  9'd192}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One clock: drive at negedge, update the model at posedge, return at negedge.
    task automatic step(input logic t, input logic w, input int d);
        tick = t;
        wr_en = w;
        duty_in = 8'(d);
        @(posedge clk);
        if (t) begin
            if (m_cnt == 255) begin
                m_cnt = 0;
                m_active = m_shadow;
            end else begin
                m_cnt++;
            end
        end
        if (w) m_shadow = d;
        @(negedge clk);
        tick = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_cnt = 0;
        m_shadow = 0;
        m_active = 0;
    endtask

    task automatic run_to(input int target);
        while (m_cnt != target) step(1'b1, 1'b0, 0);
    endtask

    // Starts at count 0, counts high ticks over one period.
    task automatic measure(output int high);
        high = 0;
        for (int i = 0; i < 256; i++) begin
            if (pwm_o === 1'b1) high++;
            step(1'b1, 1'b0, 0);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int hi;
        int mism;
        @(negedge clk);
        do_reset();

        // R1: output high right after reset, and over a full period with nothing written
        check("R1 pin after reset", int'(pwm_o), 1);
        measure(hi);
        check("R1 high ticks with cleared registers", hi, 256);

        // Vector table: mid-period write (R5), loaded at wrap (R6), duty (R4)
        for (int v = 0; v < NV; v++) begin
            run_to(100);
            step(1'b1, 1'b1, int'(VECS[v].duty));
            mism = 0;
            while (m_cnt != 0) begin
                step(1'b1, 1'b0, 0);
                if (pwm_o !== ((m_cnt >= m_active) ? 1'b1 : 1'b0)) mism++;
            end
            check("R5 old waveform kept after mid-period write", mism, 0);
            check("R6 value loaded at wrap", m_active, int'(VECS[v].duty));
            measure(hi);
            check("R4 high ticks per period", hi, int'(VECS[v].high));
        end

        // R7: write on the wrap edge loads the old shadow (64), new value next time
        run_to(255);
        step(1'b1, 1'b1, 192);
        measure(hi);
        check("R7 period after coincident write uses old shadow", hi, 192);
        measure(hi);
        check("R7 following period uses new value", hi, 64);

        // R2 and R3: active is 192 now
        run_to(150);
        mism = 0;
        for (int i = 0; i < 40; i++) begin
            step(1'b0, 1'b0, 0);
            if (pwm_o !== 1'b0) mism++;
        end
        check("R2 pin holds low without ticks", mism, 0);
        run_to(191);
        check("R3 pin low at count 191 with value 192", int'(pwm_o), 0);
        step(1'b1, 1'b0, 0);
        check("R3 pin high at count 192 with value 192", int'(pwm_o), 1);
        // 64 more ticks must reach the wrap exactly; without ticks nothing moves
        for (int i = 0; i < 30; i++) step(1'b0, 1'b0, 0);
        check("R2 pin holds high without ticks", int'(pwm_o), 1);
        for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 0);
        check("R2 count back at zero after 256 ticks", int'(pwm_o), 0);

        // R8: two writes in one period, with tick low; the last one wins
        run_to(40);
        step(1'b0, 1'b1, 10);
        step(1'b1, 1'b1, 240);
        run_to(0);
        measure(hi);
        check("R8 last write wins", hi, 16);

        // R1: reset mid-run restores full-high output
        run_to(20);
        do_reset();
        check("R1 pin after mid-run reset", int'(pwm_o), 1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 0);
        run_to(0);
        measure(hi);
        check("R1 full high after reset and wrap", hi, 256);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule